// File: doc/BRIEF.md
# Card Command and Response Sequencer

This block sends a single command to a memory card and collects what comes back. Software writes an argument word and a command word through a small register write port. When the command word arrives with its enable bit set, the block presents the command index and argument to the card side. It holds a request line high until the card acknowledges. Along with the acknowledge, the card reports an error or a byte count, and a valid response is then streamed one byte per strobe.

The sequencer checks the reported count against the kind of response the command asked for. It packs valid bytes into four 32-bit response words and records the outcome in three sticky status flags: command sent, response received and timeout. A one-cycle completion pulse lets a neighbouring data engine start in the same cycle. Stalled-command and wait-for-interrupt modes are not implemented; a request for either is reported on a one-cycle pulse.

Top module: `card_cmd_seq`

## Requirements
- R1: The command word holds the index in bits [5:0], expect-response in bit 6, long-response in bit 7, wait-for-interrupt in bit 8, hold-pending in bit 9 and enable in bit 10. A command-word write (reg_sel=1) with bit 10 set and bit 9 clear, made while idle, raises card_req in the next cycle. While card_req is high, card_index carries the written index and card_arg carries the stored argument (reg_sel=0).
- R2: If bit 6 is clear and the card acknowledges without error, st_sent becomes set.
- R3: If bit 6 is set, st_timeout becomes set and the response words keep their values when any of these holds: the card reports an error, the count is 0, the count is 4 while bit 7 is set, or the count is neither 4 nor 16.
- R4: An accepted response sets st_resp_end. Each run of four received bytes forms one 32-bit word, with the earliest byte in bits [31:24]. The first run goes to resp0.
- R5: After a 4-byte response, resp1 to resp3 read zero. After a 16-byte response (accepted even when bit 7 is clear), resp0 to resp3 hold the sixteen bytes and bit 0 of resp3 reads zero.
- R6: Bit 10 of cmd_word reads one while a command is in progress and zero once it has been handled, whatever the outcome.
- R7: With bits 10 and 9 both set, no request is raised, bit 10 is stored as zero and mode_unsup pulses. With bit 8 set (and bit 9 clear), the command runs normally and mode_unsup pulses.
- R8: A card error also sets st_timeout when no response was expected, and st_sent stays clear.
- R9: cmd_done is high for exactly one cycle. It follows the clock edge that samples the acknowledge (for outcomes without bytes) or the last response byte.
- R10: Reset clears all registers, responses and flags to zero. Flags are otherwise never cleared.
- R11: Register writes made while a command is in progress are ignored. Byte strobes outside the receive phase have no effect.
- R12: A command-word write with bit 10 clear stores the word and issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the argument word, 1 the command word |
| reg_wdata | input | 32 | Write data |
| arg_word | output | 32 | Stored argument |
| cmd_word | output | 32 | Stored command word; bit 10 is the live enable |
| card_req | output | 1 | Command offered to the card, held until acknowledge |
| card_index | output | 6 | Command index toward the card |
| card_arg | output | 32 | Argument toward the card |
| card_ack | input | 1 | Card has answered the request |
| card_err | input | 1 | Card rejected the command (qualified by card_ack) |
| card_len | input | 5 | Response byte count (qualified by card_ack) |
| card_bvalid | input | 1 | Response byte strobe |
| card_byte | input | 8 | Response byte |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| st_sent | output | 1 | Sticky: command sent with no response expected |
| st_resp_end | output | 1 | Sticky: valid response received |
| st_timeout | output | 1 | Sticky: command timed out or failed |
| cmd_done | output | 1 | One-cycle completion pulse |
| mode_unsup | output | 1 | One-cycle pulse: an unsupported wait mode was requested |

## Verification
Commands are tried with every reply class. These are a plain acknowledge with no response wanted, an error with and without a response wanted, counts of 0, 8, and 4 under a long request, valid short and long responses, and 16 bytes under a short request. Together they separate the sent, timeout and response outcomes and show that a rejected reply leaves earlier response words intact. Byte streams with idle gaps and odd final bytes test the earliest-byte-first packing, the zeroing of the upper words after a short reply and the cleared final bit. Writes made in the middle of a reply, stray strobes while idle, and the pending, interrupt-wait and non-enabled command words show which inputs must leave state alone.

// File: rtl/cardseq_pkg.sv
package cardseq_pkg;

    localparam int WORD_W      = 32;
    localparam int IDX_W       = 6;
    localparam int LEN_W       = 5;
    localparam int BYTE_W      = 8;
    localparam int SHORT_BYTES = 4;
    localparam int LONG_BYTES  = 16;
    localparam int RESP_WORDS  = (LONG_BYTES * BYTE_W) / WORD_W;

    // command word field positions
    localparam int F_WANT = 6;
    localparam int F_LONG = 7;
    localparam int F_IRQW = 8;
    localparam int F_PEND = 9;
    localparam int F_EN   = 10;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ASK,
        SQ_RECV
    } sq_state_e;

    typedef enum logic [1:0] {
        OC_NONE,
        OC_SENT,
        OC_RESP,
        OC_TMO
    } outcome_e;

    typedef struct packed {
        logic sent;
        logic resp_end;
        logic tmo;
    } seq_flags_t;

    // classify the card's answer against what the command asked for
    function automatic outcome_e judge_reply(
        input logic             err,
        input logic             want,
        input logic             lng,
        input logic [LEN_W-1:0] n
    );
        if (err)
            return OC_TMO;
        if (!want)
            return OC_SENT;
        if (n == '0)
            return OC_TMO;
        if (n == LEN_W'(SHORT_BYTES) && lng)
            return OC_TMO;
        if (n != LEN_W'(SHORT_BYTES) && n != LEN_W'(LONG_BYTES))
            return OC_TMO;
        return OC_RESP;
    endfunction

endpackage

// File: rtl/cardseq_fsm.sv
module cardseq_fsm
    import cardseq_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          want,
    input  logic          lng,
    input  logic          card_ack,
    input  logic          card_err,
    input  logic [LW-1:0] card_len,
    input  logic          card_bvalid,
    output logic          card_req,
    output logic          take_byte,
    output logic          fin,
    output outcome_e      fin_kind,
    output logic [LW-1:0] resp_len
);

    sq_state_e      st_q, st_d;
    logic [LW-1:0]  rlen_q, cnt_q;
    outcome_e       verdict;

    assign verdict   = judge_reply(card_err, want, lng, card_len);
    assign card_req  = (st_q == SQ_ASK);
    assign take_byte = (st_q == SQ_RECV) && card_bvalid;
    assign resp_len  = rlen_q;

    always_comb begin
        st_d     = st_q;
        fin      = 1'b0;
        fin_kind = OC_NONE;
        case (st_q)
            SQ_IDLE: begin
                if (launch)
                    st_d = SQ_ASK;
            end
            SQ_ASK: begin
                if (card_ack) begin
                    if (verdict == OC_RESP) begin
                        st_d = SQ_RECV;
                    end else begin
                        fin      = 1'b1;
                        fin_kind = verdict;
                        st_d     = SQ_IDLE;
                    end
                end
            end
            SQ_RECV: begin
                if (card_bvalid && cnt_q == rlen_q - LW'(1)) begin
                    fin      = 1'b1;
                    fin_kind = OC_RESP;
                    st_d     = SQ_IDLE;
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            rlen_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_ASK && card_ack) begin
                rlen_q <= card_len;
                cnt_q  <= '0;
            end else if (take_byte) begin
                cnt_q <= cnt_q + LW'(1);
            end
        end
    end

endmodule

// File: rtl/cardseq_shaper.sv
module cardseq_shaper
    import cardseq_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int BW = BYTE_W,
    parameter int NB = LONG_BYTES,
    parameter int LW = LEN_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     take_byte,
    input  logic [BW-1:0]            byte_in,
    input  logic                     load,
    input  logic [LW-1:0]            resp_len,
    output logic [(NB*BW/WW)-1:0][WW-1:0] resp_q
);

    localparam int BUF_W = NB * BW;
    localparam int NW    = BUF_W / WW;

    logic [BUF_W-1:0]         buf_q, buf_d;
    logic [NW-1:0][WW-1:0]    shaped;
    logic                     is_long;

    // newest byte enters at the bottom, so the earliest sits highest
    assign buf_d   = take_byte ? {buf_q[BUF_W-BW-1:0], byte_in} : buf_q;
    assign is_long = (resp_len == LW'(NB));

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [WW-1:0] lw;
        assign lw = buf_d[BUF_W-1-w*WW -: WW];
        if (w == 0) begin : g_first
            assign shaped[w] = is_long ? lw : buf_d[WW-1:0];
        end else if (w == NW-1) begin : g_last
            assign shaped[w] = is_long ? {lw[WW-1:1], 1'b0} : '0;
        end else begin : g_mid
            assign shaped[w] = is_long ? lw : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            resp_q <= '0;
        end else begin
            buf_q <= buf_d;
            if (load)
                resp_q <= shaped;
        end
    end

endmodule

// File: rtl/card_cmd_seq.sv
module card_cmd_seq
    import cardseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] arg_word,
    output logic [WORD_W-1:0] cmd_word,
    output logic              card_req,
    output logic [IDX_W-1:0]  card_index,
    output logic [WORD_W-1:0] card_arg,
    input  logic              card_ack,
    input  logic              card_err,
    input  logic [LEN_W-1:0]  card_len,
    input  logic              card_bvalid,
    input  logic [BYTE_W-1:0] card_byte,
    output logic [WORD_W-1:0] resp0,
    output logic [WORD_W-1:0] resp1,
    output logic [WORD_W-1:0] resp2,
    output logic [WORD_W-1:0] resp3,
    output logic              st_sent,
    output logic              st_resp_end,
    output logic              st_timeout,
    output logic              cmd_done,
    output logic              mode_unsup
);

    logic [WORD_W-1:0]                  arg_q, cmd_q;
    seq_flags_t                         flg_q;
    logic                               done_q, unsup_q;
    logic                               busy, wr_ok, cmd_wr, fire, launch;
    logic                               take_byte, fin, load;
    outcome_e                           fin_kind;
    logic [LEN_W-1:0]                   resp_len;
    logic [RESP_WORDS-1:0][WORD_W-1:0]  resp_q;

    // the stored enable bit doubles as the busy indication
    assign busy   = cmd_q[F_EN];
    assign wr_ok  = reg_wr && !busy;
    assign cmd_wr = wr_ok && reg_sel;
    assign fire   = cmd_wr && reg_wdata[F_EN];
    assign launch = fire && !reg_wdata[F_PEND];
    assign load   = fin && (fin_kind == OC_RESP);

    cardseq_fsm #(.LW(LEN_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .want        (cmd_q[F_WANT]),
        .lng         (cmd_q[F_LONG]),
        .card_ack    (card_ack),
        .card_err    (card_err),
        .card_len    (card_len),
        .card_bvalid (card_bvalid),
        .card_req    (card_req),
        .take_byte   (take_byte),
        .fin         (fin),
        .fin_kind    (fin_kind),
        .resp_len    (resp_len)
    );

    cardseq_shaper #(
        .WW (WORD_W),
        .BW (BYTE_W),
        .NB (LONG_BYTES),
        .LW (LEN_W)
    ) u_shaper (
        .clk       (clk),
        .rst       (rst),
        .take_byte (take_byte),
        .byte_in   (card_byte),
        .load      (load),
        .resp_len  (resp_len),
        .resp_q    (resp_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            arg_q   <= '0;
            cmd_q   <= '0;
            flg_q   <= '0;
            done_q  <= 1'b0;
            unsup_q <= 1'b0;
        end else begin
            done_q  <= fin;
            unsup_q <= fire && (reg_wdata[F_PEND] || reg_wdata[F_IRQW]);
            if (wr_ok && !reg_sel)
                arg_q <= reg_wdata;
            if (cmd_wr) begin
                cmd_q       <= reg_wdata;
                cmd_q[F_EN] <= launch;
            end else if (fin) begin
                cmd_q[F_EN] <= 1'b0;
            end
            if (fin) begin
                case (fin_kind)
                    OC_SENT: flg_q.sent     <= 1'b1;
                    OC_RESP: flg_q.resp_end <= 1'b1;
                    OC_TMO:  flg_q.tmo      <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign arg_word    = arg_q;
    assign cmd_word    = cmd_q;
    assign card_index  = cmd_q[IDX_W-1:0];
    assign card_arg    = arg_q;
    assign resp0       = resp_q[0];
    assign resp1       = resp_q[1];
    assign resp2       = resp_q[2];
    assign resp3       = resp_q[3];
    assign st_sent     = flg_q.sent;
    assign st_resp_end = flg_q.resp_end;
    assign st_timeout  = flg_q.tmo;
    assign cmd_done    = done_q;
    assign mode_unsup  = unsup_q;

endmodule

// File: rtl/cardseq_chk.sv
module cardseq_chk
    import cardseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] cmd_word,
    input logic              card_req,
    input logic [IDX_W-1:0]  card_index,
    input logic              card_ack,
    input logic              card_err,
    input logic [WORD_W-1:0] resp3,
    input logic              st_sent,
    input logic              st_resp_end,
    input logic              st_timeout,
    input logic              cmd_done,
    input logic              mode_unsup
);

    assert_issue_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && reg_wdata[F_EN] && !reg_wdata[F_PEND] && !cmd_word[F_EN])
        |=> (card_req && card_index == $past(reg_wdata[IDX_W-1:0])));

    assert_sent_R2: assert property (@(posedge clk) disable iff (rst)
        (card_req && card_ack && !card_err && !cmd_word[F_WANT])
        |=> (st_sent && cmd_done));

    assert_bit0_R5: assert property (@(posedge clk) disable iff (rst)
        !resp3[0]);

    assert_en_clear_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> !cmd_word[F_EN]);

    assert_pending_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && reg_wdata[F_EN] && reg_wdata[F_PEND] && !cmd_word[F_EN])
        |=> (!card_req && !cmd_word[F_EN] && mode_unsup));

    assert_err_tmo_R8: assert property (@(posedge clk) disable iff (rst)
        (card_req && card_ack && card_err) |=> (st_timeout && cmd_done));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !$fell(st_sent) && !$fell(st_resp_end) && !$fell(st_timeout));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !cmd_word[F_EN] |-> !card_req);

endmodule

bind card_cmd_seq cardseq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .cmd_word    (cmd_word),
    .card_req    (card_req),
    .card_index  (card_index),
    .card_ack    (card_ack),
    .card_err    (card_err),
    .resp3       (resp3),
    .st_sent     (st_sent),
    .st_resp_end (st_resp_end),
    .st_timeout  (st_timeout),
    .cmd_done    (cmd_done),
    .mode_unsup  (mode_unsup)
);

// File: tb/card_cmd_seq_test.sv
module card_cmd_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] arg_word, cmd_word, card_arg;
    logic        card_req;
    logic [5:0]  card_index;
    logic        card_ack = 1'b0;
    logic        card_err = 1'b0;
    logic [4:0]  card_len = '0;
    logic        card_bvalid = 1'b0;
    logic [7:0]  card_byte = '0;
    logic [31:0] resp0, resp1, resp2, resp3;
    logic        st_sent, st_resp_end, st_timeout, cmd_done, mode_unsup;

    always #2 clk = ~clk;

    card_cmd_seq uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .arg_word(arg_word), .cmd_word(cmd_word), .card_req(card_req),
        .card_index(card_index), .card_arg(card_arg), .card_ack(card_ack),
        .card_err(card_err), .card_len(card_len), .card_bvalid(card_bvalid),
        .card_byte(card_byte), .resp0(resp0), .resp1(resp1), .resp2(resp2),
        .resp3(resp3), .st_sent(st_sent), .st_resp_end(st_resp_end),
        .st_timeout(st_timeout), .cmd_done(cmd_done), .mode_unsup(mode_unsup)
    );

    typedef struct {
        logic [3:0][31:0] r;
        logic [2:0]       fl;
        string            tag;
    } exp_t;

    exp_t             sbq[$];
    logic [3:0][31:0] m_resp = '0;
    logic [2:0]       m_fl = '0;   // {sent, resp_end, timeout}
    int               checks = 0;
    int               fails = 0;
    bit               prev_done = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 13 + i * 29 + 5) & 255);
    endfunction

    task automatic write_reg(input logic sel, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_sel   = sel;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_resp = '0;
        m_fl   = '0;
        sbq.delete();
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev_done = 1'b0;
            end else begin
                if (cmd_done) begin
                    if (prev_done) chk("R9", "done longer than one cycle", 1, 0);
                    if (sbq.size() == 0) begin
                        chk("R9", "unexpected done", 1, 0);
                    end else begin
                        e = sbq.pop_front();
                        chk(e.tag, "resp0", resp0, e.r[0]);
                        chk(e.tag, "resp1", resp1, e.r[1]);
                        chk(e.tag, "resp2", resp2, e.r[2]);
                        chk(e.tag, "resp3", resp3, e.r[3]);
                        chk(e.tag, "flags", {st_sent, st_resp_end, st_timeout}, e.fl);
                        chk("R6", "enable after done", cmd_word[10], 0);
                    end
                end
                prev_done = cmd_done;
            end
        end
    end

    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input logic want, input logic lng, input logic irqw,
                           input logic err, input logic [4:0] len,
                           input int seed, input bit poke);
        logic [31:0] cw;
        exp_t        e;
        int          kind;   // 1 sent, 2 resp, 3 timeout
        cw = '0;
        cw[5:0] = idx; cw[6] = want; cw[7] = lng; cw[8] = irqw; cw[10] = 1'b1;
        if (err) kind = 3;
        else if (!want) kind = 1;
        else if (len == 0 || (len == 4 && lng) || (len != 4 && len != 16)) kind = 3;
        else kind = 2;
        if (kind == 1) begin m_fl[2] = 1'b1; e.tag = "R2"; end
        else if (kind == 3) begin m_fl[0] = 1'b1; e.tag = (!want) ? "R8" : "R3"; end
        else begin
            m_fl[1] = 1'b1;
            e.tag = (len == 16) ? "R5" : "R4";
            m_resp = '0;
            if (len == 16) begin
                for (int k = 0; k < 4; k++)
                    m_resp[k] = {pat(seed, 4*k), pat(seed, 4*k+1), pat(seed, 4*k+2), pat(seed, 4*k+3)};
                m_resp[3][0] = 1'b0;
            end else begin
                m_resp[0] = {pat(seed, 0), pat(seed, 1), pat(seed, 2), pat(seed, 3)};
            end
        end
        e.r  = m_resp;
        e.fl = m_fl;
        sbq.push_back(e);

        write_reg(1'b0, arg);
        write_reg(1'b1, cw);
        chk("R7", "unsupported pulse", mode_unsup, irqw);
        chk("R6", "enable while busy", cmd_word[10], 1);
        chk("R1", "request raised", card_req, 1);
        chk("R1", "index", card_index, idx);
        chk("R1", "argument", card_arg, arg);

        card_ack = 1'b1; card_err = err; card_len = len;
        @(negedge clk);
        card_ack = 1'b0; card_err = 1'b0; card_len = '0;
        if (kind == 2) begin
            for (int i = 0; i < len; i++) begin
                if (poke && i == 2) begin
                    write_reg(1'b0, ~arg);
                    write_reg(1'b1, 32'h0000_07FF);
                end
                if (i % 3 == 1) @(negedge clk);
                card_bvalid = 1'b1;
                card_byte   = pat(seed, i);
                @(negedge clk);
                card_bvalid = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        chk("R9", "done consumed", sbq.size(), 0);
        if (poke) begin
            chk("R11", "argument kept during busy", arg_word, arg);
            chk("R11", "command kept during busy", cmd_word, cw & ~32'h400);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10", "reset responses", {resp0, resp1, resp2, resp3}, 128'd0);
        chk("R10", "reset flags", {st_sent, st_resp_end, st_timeout, cmd_done, mode_unsup}, 0);
        chk("R10", "reset regs", {arg_word, cmd_word}, 64'd0);

        // R12 non-enabled command word
        write_reg(1'b1, 32'h0000_00C5);
        chk("R12", "stored word", cmd_word, 32'h0000_00C5);
        @(negedge clk);
        chk("R12", "no request", card_req, 0);

        run_cmd(6'd0, 32'h0000_0000, 0, 0, 0, 0, 5'd0, 0, 0);          // R2
        run_cmd(6'd17, 32'h1234_5678, 1, 0, 0, 0, 5'd4, 4, 0);         // R4 short
        run_cmd(6'd2, 32'hCAFE_0001, 1, 1, 0, 0, 5'd16, 7, 1);         // R5 long, R11 pokes
        run_cmd(6'd13, 32'h0000_0042, 1, 0, 0, 0, 5'd4, 10, 0);        // R5 short zeroes upper
        run_cmd(6'd9, 32'h0000_0009, 1, 0, 0, 0, 5'd16, 3, 0);         // R5 16 bytes under short

        do_reset();
        run_cmd(6'd17, 32'hA5A5_0000, 1, 0, 0, 0, 5'd4, 21, 0);
        run_cmd(6'd18, 32'hA5A5_0001, 1, 0, 0, 1, 5'd4, 0, 0);         // R3 error

        do_reset();
        run_cmd(6'd17, 32'h0000_1111, 1, 0, 0, 0, 5'd4, 33, 0);
        run_cmd(6'd2, 32'h0000_2222, 1, 1, 0, 0, 5'd4, 0, 0);          // R3 short under long

        do_reset();
        run_cmd(6'd17, 32'h0000_3333, 1, 0, 0, 0, 5'd4, 45, 0);
        run_cmd(6'd3, 32'h0000_4444, 1, 0, 0, 0, 5'd0, 0, 0);          // R3 zero length

        do_reset();
        run_cmd(6'd17, 32'h0000_5555, 1, 1, 0, 0, 5'd16, 51, 0);
        run_cmd(6'd7, 32'h0000_6666, 1, 0, 0, 0, 5'd8, 0, 0);          // R3 odd length
        // R11 stray strobes while idle
        for (int i = 0; i < 3; i++) begin
            card_bvalid = 1'b1; card_byte = 8'hF0 + 8'(i);
            @(negedge clk);
        end
        card_bvalid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11", "stray bytes resp0", resp0, m_resp[0]);
        chk("R11", "stray bytes resp3", resp3, m_resp[3]);

        do_reset();
        run_cmd(6'd0, 32'h0000_0000, 0, 0, 0, 1, 5'd0, 0, 0);          // R8

        // R7 pending mode
        write_reg(1'b1, 32'h0000_0611);
        chk("R7", "pending unsup pulse", mode_unsup, 1);
        chk("R7", "pending enable cleared", cmd_word[10], 0);
        chk("R7", "pending no request", card_req, 0);
        repeat (4) @(negedge clk);
        chk("R7", "pending still no request", card_req, 0);
        chk("R7", "pulse dropped", mode_unsup, 0);

        run_cmd(6'd25, 32'h0BAD_F00D, 1, 0, 1, 0, 5'd4, 61, 0);        // R7 interrupt-wait

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule